// File: doc/BRIEF.md
# Clock Loss Monitor with Backup Switching

This block supervises two clocks, the PLL reference clock and the PLL output clock, from a free-running check clock. Each supervised clock drives a toggle flop. The check-clock domain synchronizes that toggle and counts the check cycles that pass without seeing it change. If the count reaches a window of `WIN` cycles, the clock is declared lost. Each loss sets a sticky flag. Software clears a flag by writing one to it. Two enables decide whether a set flag raises the interrupt request, the system reset request, or both.

The system clock normally comes from the PLL output. While any loss flag is set, the system clock moves to a backup source chosen by software: the reference clock, or the PLL output running free. The switch is glitch-free. Each clock branch owns a two-flop enable chain. A branch may turn on only after the other branch's enable has gone low. The enable of a branch whose clock is lost is cleared from the check domain, so a dead branch cannot hold the switch.

When the crystal reference is selected, the block holds two conditions after reset: the system clock stays gated and the system reset request stays asserted. Both hold until `STABLE_EDGES` reference edges have been observed in a row with no reference loss. From then on the oscillator is considered stable until the next reset.

Top module: `clk_loss_mon`

## Requirements
- R1: After reset, both loss flags, `irq_o` and `stable_o` are 0.
- R2: If the reference clock shows no transition for 256 check-clock cycles, `ref_lost_o` becomes 1. A running reference never sets it.
- R3: If the PLL clock shows no transition for 256 check-clock cycles, `pll_lost_o` becomes 1. A running PLL clock never sets it.
- R4: Loss flags are sticky. A one-cycle pulse on `clr_ref_i` or `clr_pll_i` clears only its own flag. The clear has no effect while that clock is still absent, because a set takes priority over a clear.
- R5: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one loss flag is set.
- R6: `rst_req_o` is 1 when `rst_en_i` is 1 and a loss flag is set, or when the crystal stabilization hold is active. Otherwise it is 0.
- R7: With `xtal_ref_i`=1, `sys_clk_o` makes no edges and `rst_req_o` stays 1 until 4096 consecutive reference edges have been seen. `stable_o` then rises and remains 1 until reset.
- R8: A reference loss before stability restarts the edge count from zero.
- R9: With `xtal_ref_i`=0, no stabilization hold applies, and `sys_clk_o` follows the PLL clock right after reset.
- R10: With no flag set, `sys_clk_o` follows the PLL clock. With a flag set, it follows the reference clock if `backup_sel_i`=0, or the PLL clock if `backup_sel_i`=1.
- R11: The two branch enables are never both active, and no high pulse on `sys_clk_o` is shorter than the high phase of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk_i | input | 1 | Free-running check clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | PLL reference clock being monitored |
| pll_clk_i | input | 1 | PLL output clock being monitored |
| xtal_ref_i | input | 1 | 1 = crystal reference in use (stabilization hold applies) |
| irq_en_i | input | 1 | Let loss flags raise the interrupt |
| rst_en_i | input | 1 | Let loss flags raise the reset request |
| backup_sel_i | input | 1 | Backup source: 0 reference, 1 PLL free-running |
| clr_ref_i | input | 1 | Write-one-to-clear for the reference loss flag |
| clr_pll_i | input | 1 | Write-one-to-clear for the PLL loss flag |
| ref_lost_o | output | 1 | Sticky reference loss flag |
| pll_lost_o | output | 1 | Sticky PLL loss flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| stable_o | output | 1 | Oscillator judged stable |
| sys_clk_o | output | 1 | Selected, gated system clock |

## Verification
The bench stops the reference clock and the PLL clock in separate phases. This shows whether a flag follows its own clock and whether the detector confuses the two. It counts `sys_clk_o` edges over fixed windows, and the PLL and reference periods give different counts, so the count reveals which source drives the system clock after every switch. A reference dropout partway through stabilization separates a count that restarts from one that only pauses. Random rounds combine enable settings, backup choices and the stopped clock, and a bench model predicts the flags and requests for each round.

// File: rtl/clm_pkg.sv
`timescale 1ns/1ps
package clm_pkg;
  typedef enum logic {SRC_REF = 1'b0, SRC_PLL = 1'b1} clk_src_e;
  localparam int unsigned NUM_MON = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_PLL = 1;
endpackage

// File: rtl/clm_act_det.sv
`timescale 1ns/1ps
module clm_act_det #(
  parameter int unsigned WIN = 256
) (
  input  logic mon_clk_i,
  input  logic chk_clk_i,
  input  logic rst_ni,
  output logic act_o,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic       tgl_q;
  logic [2:0] sync_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge mon_clk_i or negedge rst_ni)
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;

  always_ff @(posedge chk_clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_q};

  assign act_o = sync_q[2] ^ sync_q[1];

  always_ff @(posedge chk_clk_i or negedge rst_ni)
    if (!rst_ni)                  idle_q <= '0;
    else if (act_o)               idle_q <= '0;
    else if (idle_q != CW'(WIN))  idle_q <= idle_q + 1'b1;

  assign lost_o = (idle_q == CW'(WIN));
endmodule

// File: rtl/clm_stab_cnt.sv
`timescale 1ns/1ps
module clm_stab_cnt #(
  parameter int unsigned EDGES = 4096
) (
  input  logic chk_clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic lost_i,
  output logic stable_o
);
  localparam int unsigned CW = $clog2(EDGES + 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge chk_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (lost_i)                      cnt_q <= '0;
      else if (cnt_q == CW'(EDGES))    stable_q <= 1'b1;
      else if (act_i)                  cnt_q <= cnt_q + 1'b1;
    end

  assign stable_o = stable_q;
endmodule

// File: rtl/clm_gate_branch.sv
`timescale 1ns/1ps
module clm_gate_branch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic req_i,
  output logic en_o
);
  logic clr_n;
  logic s1_q;
  logic en_q;

  // a dead clock cannot drop its own enable; the check domain does it
  assign clr_n = rst_ni & ~kill_i;

  always_ff @(posedge clk_i or negedge clr_n)
    if (!clr_n) s1_q <= 1'b0;
    else        s1_q <= req_i;

  // change the enable only while the clock is low
  always_ff @(negedge clk_i or negedge clr_n)
    if (!clr_n) en_q <= 1'b0;
    else        en_q <= s1_q;

  assign en_o = en_q;
endmodule

// File: rtl/clk_loss_mon.sv
`timescale 1ns/1ps
module clk_loss_mon
  import clm_pkg::*;
#(
  parameter int unsigned WIN          = 256,
  parameter int unsigned STABLE_EDGES = 4096
) (
  input  logic chk_clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic pll_clk_i,
  input  logic xtal_ref_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  input  logic backup_sel_i,
  input  logic clr_ref_i,
  input  logic clr_pll_i,
  output logic ref_lost_o,
  output logic pll_lost_o,
  output logic irq_o,
  output logic rst_req_o,
  output logic stable_o,
  output logic sys_clk_o
);
  logic [NUM_MON-1:0] mon_clk, det_act, det_lost, clr, flag_q, kill_q, want_q, en, req;
  logic     stable, open_gate;
  clk_src_e src;

  assign mon_clk[IDX_REF] = ref_clk_i;
  assign mon_clk[IDX_PLL] = pll_clk_i;
  assign clr[IDX_REF]     = clr_ref_i;
  assign clr[IDX_PLL]     = clr_pll_i;

  for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
    clm_act_det #(.WIN(WIN)) u_det (
      .mon_clk_i (mon_clk[i]),
      .chk_clk_i (chk_clk_i),
      .rst_ni    (rst_ni),
      .act_o     (det_act[i]),
      .lost_o    (det_lost[i])
    );

    // set wins over clear
    always_ff @(posedge chk_clk_i or negedge rst_ni)
      if (!rst_ni)          flag_q[i] <= 1'b0;
      else if (det_lost[i]) flag_q[i] <= 1'b1;
      else if (clr[i])      flag_q[i] <= 1'b0;

    // branch kill held until the clock shows activity again
    always_ff @(posedge chk_clk_i or negedge rst_ni)
      if (!rst_ni)          kill_q[i] <= 1'b0;
      else if (det_lost[i]) kill_q[i] <= 1'b1;
      else if (det_act[i])  kill_q[i] <= 1'b0;

    assign req[i] = want_q[i] & ~en[NUM_MON-1-i];

    clm_gate_branch u_br (
      .clk_i  (mon_clk[i]),
      .rst_ni (rst_ni),
      .kill_i (kill_q[i]),
      .req_i  (req[i]),
      .en_o   (en[i])
    );
  end

  clm_stab_cnt #(.EDGES(STABLE_EDGES)) u_stab (
    .chk_clk_i (chk_clk_i),
    .rst_ni    (rst_ni),
    .act_i     (det_act[IDX_REF]),
    .lost_i    (det_lost[IDX_REF]),
    .stable_o  (stable)
  );

  assign open_gate = stable | ~xtal_ref_i;
  assign src       = (|flag_q) ? clk_src_e'(backup_sel_i) : SRC_PLL;

  always_ff @(posedge chk_clk_i or negedge rst_ni)
    if (!rst_ni) want_q <= '0;
    else begin
      want_q[IDX_REF] <= open_gate & (src == SRC_REF);
      want_q[IDX_PLL] <= open_gate & (src == SRC_PLL);
    end

  assign sys_clk_o  = |(mon_clk & en);
  assign ref_lost_o = flag_q[IDX_REF];
  assign pll_lost_o = flag_q[IDX_PLL];
  assign stable_o   = stable;
  assign irq_o      = irq_en_i & (|flag_q);
  assign rst_req_o  = (xtal_ref_i & ~stable) | (rst_en_i & (|flag_q));
endmodule

// File: rtl/clk_loss_mon_chk.sv
`timescale 1ns/1ps
module clk_loss_mon_chk (
  input logic       chk_clk_i,
  input logic       rst_ni,
  input logic       xtal_ref_i,
  input logic       irq_en_i,
  input logic       clr_ref_i,
  input logic       clr_pll_i,
  input logic       ref_lost_o,
  input logic       pll_lost_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       stable_o,
  input logic [1:0] det_lost,
  input logic [1:0] en
);
  AST_REF_LOSS_FLAGS: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    det_lost[0] |=> ref_lost_o); // R2
  AST_PLL_LOSS_FLAGS: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    det_lost[1] |=> pll_lost_o); // R3
  AST_REF_FLAG_STICKY: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    ref_lost_o && !clr_ref_i |=> ref_lost_o); // R4
  AST_PLL_FLAG_STICKY: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    pll_lost_o && !clr_pll_i |=> pll_lost_o); // R4
  AST_IRQ_MASKED: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R5
  AST_HOLD_UNTIL_STABLE: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    xtal_ref_i && !stable_o |-> rst_req_o); // R7
  AST_STABLE_KEEPS: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    stable_o |=> stable_o); // R7
  AST_BRANCH_EXCL: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    !(en[0] && en[1])); // R11
endmodule

bind clk_loss_mon clk_loss_mon_chk u_chk (
  .chk_clk_i  (chk_clk_i),
  .rst_ni     (rst_ni),
  .xtal_ref_i (xtal_ref_i),
  .irq_en_i   (irq_en_i),
  .clr_ref_i  (clr_ref_i),
  .clr_pll_i  (clr_pll_i),
  .ref_lost_o (ref_lost_o),
  .pll_lost_o (pll_lost_o),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .stable_o   (stable_o),
  .det_lost   (det_lost),
  .en         (en)
);

// File: tb/tb_clk_loss_mon.sv
`timescale 1ns/1ps
module tb_clk_loss_mon;
  logic chk_clk = 1'b0, ref_clk = 1'b0, pll_clk = 1'b0;
  logic ref_on = 1'b1, pll_on = 1'b1;
  logic rst_ni = 1'b0, xtal_ref = 1'b1;
  logic irq_en = 1'b0, rst_en = 1'b0, backup_sel = 1'b0;
  logic clr_ref = 1'b0, clr_pll = 1'b0;
  logic ref_lost, pll_lost, irq, rst_req, stable, sys_clk;

  int   n_chk = 0, n_bad = 0;
  int   sys_edges = 0;
  bit   meas_on = 1'b0, finished = 1'b0;
  realtime t_rise = 0.0, min_hi = 1.0e9;

  clk_loss_mon dut (
    .chk_clk_i(chk_clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .pll_clk_i(pll_clk),
    .xtal_ref_i(xtal_ref), .irq_en_i(irq_en), .rst_en_i(rst_en), .backup_sel_i(backup_sel),
    .clr_ref_i(clr_ref), .clr_pll_i(clr_pll), .ref_lost_o(ref_lost), .pll_lost_o(pll_lost),
    .irq_o(irq), .rst_req_o(rst_req), .stable_o(stable), .sys_clk_o(sys_clk)
  );

  always #10 chk_clk = ~chk_clk;
  initial forever begin
    if (ref_on) begin #50 ref_clk = 1'b1; #50 ref_clk = 1'b0; end else #10;
  end
  initial forever begin
    if (pll_on) begin #30 pll_clk = 1'b1; #30 pll_clk = 1'b0; end else #10;
  end

  always @(posedge sys_clk) begin sys_edges++; t_rise = $realtime; end
  always @(negedge sys_clk)
    if (meas_on && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;

  function automatic logic exp_irq(logic en_b, logic fr, logic fp);
    return en_b & (fr | fp);
  endfunction
  function automatic logic exp_rst(logic en_b, logic fr, logic fp, logic x, logic st);
    return (x & ~st) | (en_b & (fr | fp));
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic check_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge chk_clk);
  endtask
  task automatic edges_in(int n, output int e);
    int s;
    @(negedge chk_clk);
    s = sys_edges;
    cyc(n);
    e = sys_edges - s;
  endtask
  task automatic pulse_clr(logic r, logic p);
    @(negedge chk_clk);
    clr_ref = r; clr_pll = p;
    @(negedge chk_clk);
    clr_ref = 1'b0; clr_pll = 1'b0;
    cyc(1);
  endtask

  initial begin
    #(3_000_000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e;
    void'($urandom(32'd5150));
    // crystal mode power-up
    cyc(3);
    rst_ni = 1'b1;
    cyc(10);
    check("R1 ref_lost", ref_lost, 0);
    check("R1 pll_lost", pll_lost, 0);
    check("R1 irq", irq, 0);
    check("R1 stable", stable, 0);
    check("R7 rst hold", rst_req, 1);
    edges_in(200, e);
    check("R7 gated edges", e, 0);
    #(100_000);
    // reference dropout before stability
    ref_on = 1'b0;
    cyc(400);
    check("R2 ref_lost", ref_lost, 1);
    check("R3 no false pll loss", pll_lost, 0);
    check("R8 not stable", stable, 0);
    check("R7 still held", rst_req, 1);
    ref_on = 1'b1;
    cyc(20);
    pulse_clr(1'b1, 1'b0);
    check("R4 clear after recovery", ref_lost, 0);
    #(400_000);
    check("R8 count restarted", stable, 0);
    check("R7 hold during count", rst_req, 1);
    #(30_000);
    check("R7 stable", stable, 1);
    check("R7 hold released", rst_req, 0);
    cyc(20);
    meas_on = 1'b1;
    edges_in(100, e);
    check_rng("R10 normal pll source", e, 31, 35);

    // pll loss, interrupt only, backup reference
    irq_en = 1'b1;
    pll_on = 1'b0;
    cyc(400);
    check("R3 pll_lost", pll_lost, 1);
    check("R2 no false ref loss", ref_lost, 0);
    check("R5 irq", irq, 1);
    check("R6 reset masked", rst_req, 0);
    edges_in(100, e);
    check_rng("R10 backup ref", e, 18, 22);
    pulse_clr(1'b0, 1'b1);
    check("R4 clear ignored while lost", pll_lost, 1);
    pll_on = 1'b1;
    cyc(20);
    pulse_clr(1'b1, 1'b0);
    check("R4 other flag untouched", pll_lost, 1);
    pulse_clr(1'b0, 1'b1);
    check("R4 pll cleared", pll_lost, 0);
    check("R5 irq drops", irq, 0);
    cyc(20);
    edges_in(100, e);
    check_rng("R10 back to pll", e, 31, 35);

    // ref loss, reset only, backup pll
    irq_en = 1'b0; rst_en = 1'b1; backup_sel = 1'b1;
    ref_on = 1'b0;
    cyc(400);
    check("R2 ref_lost", ref_lost, 1);
    check("R6 rst_req", rst_req, 1);
    check("R5 irq masked", irq, 0);
    edges_in(100, e);
    check_rng("R10 backup pll", e, 31, 35);
    ref_on = 1'b1;
    cyc(20);
    pulse_clr(1'b1, 1'b0);
    check("R6 rst_req drops", rst_req, 0);

    // random rounds
    for (int k = 0; k < 12; k++) begin
      int which;
      which      = $urandom % 3;
      irq_en     = 1'($urandom % 2);
      rst_en     = 1'($urandom % 2);
      backup_sel = 1'($urandom % 2);
      if (which == 1) ref_on = 1'b0;
      if (which == 2) pll_on = 1'b0;
      cyc(400);
      check("R2 rnd ref flag", ref_lost, (which == 1) ? 1 : 0);
      check("R3 rnd pll flag", pll_lost, (which == 2) ? 1 : 0);
      check("R5 rnd irq", irq, exp_irq(irq_en, which == 1, which == 2));
      check("R6 rnd rst", rst_req, exp_rst(rst_en, which == 1, which == 2, 1'b1, 1'b1));
      check("R7 rnd stable kept", stable, 1);
      ref_on = 1'b1; pll_on = 1'b1;
      cyc(20);
      pulse_clr(1'b1, 1'b1);
      check("R4 rnd ref cleared", ref_lost, 0);
      check("R4 rnd pll cleared", pll_lost, 0);
      cyc(20);
    end
    meas_on = 1'b0;
    check("R11 min high ns", (min_hi >= 29.0) ? 1 : 0, 1);

    // external reference: no hold
    @(negedge chk_clk);
    rst_ni = 1'b0; xtal_ref = 1'b0; irq_en = 1'b0; rst_en = 1'b0; backup_sel = 1'b0;
    cyc(5);
    rst_ni = 1'b1;
    cyc(10);
    check("R9 no hold", rst_req, 0);
    check("R1 ref_lost after reset", ref_lost, 0);
    edges_in(100, e);
    check_rng("R9 pll runs at once", e, 31, 35);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule